// File: doc/BRIEF.md
# Lane Link-Configuration Capture

This block records the link configuration data that each receive lane carries during its initial alignment sequence, and holds it for software to read. Every lane presents one decoded octet per valid cycle, together with a control-character flag, a flag that is high while the lane is in its alignment sequence, and the number of the current multiframe within that sequence. When a lane sees the /Q/ control character in the second multiframe (multiframe count 1), it stores the next fourteen data octets in its own bank. It raises a done bit when all fourteen have arrived, or an error bit if a control character breaks into the window.

Software reads the banks indirectly. A lane-select register is written first. Each read request then names one 32-bit word of the selected bank, and the word appears one cycle later with a valid strobe. The lane inputs are never back-pressured: the block takes an octet on every cycle its valid is high, so the lane streams carry no ready signal. The read path has no stall either, and each request produces exactly one response. Done and error stay plain per-lane status pins.

Top module: `ilas_cfg_capture`

## Requirements
- R1: After reset every done and error bit is 0, `rd_valid` is 0, and every stored octet reads as 0.
- R2: An octet with valid high, control flag high and value 0x9C, arriving while the lane's alignment flag is high and its multiframe count equals 1, starts a capture. It clears that lane's done and error bits, and the next data octet is stored at index 0.
- R3: A 0x9C octet without the control flag, a control 0x9C arriving in any multiframe other than count 1, and a control 0x9C arriving while the alignment flag is low all start nothing. No later octet is stored and done stays 0.
- R4: During a capture each valid data octet goes to the next index, 0 through 13, and cycles with valid low are skipped. Done goes to 1 on the clock edge that takes index 13, and not before.
- R5: A valid octet with the control flag set that arrives before index 13 is stored ends the capture. Error goes to 1, done stays 0, the octets already taken are kept, and later octets are not stored.
- R6: After a capture finishes or is aborted, the lane ignores all octets, including /Q/, until its alignment flag has been low for at least one clock edge. A later alignment sequence then re-arms the lane, and a new capture overwrites the bank.
- R7: Each lane's capture, bank, done bit and error bit are independent of every other lane.
- R8: A cycle with `sel_wr_en` high loads `sel_lane` into the lane-select register. A cycle with `rd_en` high returns word `rd_word` of the selected bank on `rd_data` one cycle later, with `rd_valid` high. Byte b of word w (bits 8b+7:8b) is octet 4w+b.
- R9: Byte positions whose octet index is 14 or more read as 0, so bits 31:16 of word 3 are 0.
- R10: A lane-select value equal to or above the number of lanes reads as all zeros.
- R11: `rd_valid` is high for exactly the one cycle after each cycle that has `rd_en` high, and it is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lane_valid | input | NUM_LANES | Per-lane octet valid |
| lane_ctrl | input | NUM_LANES | Per-lane control-character flag |
| lane_octet | input | NUM_LANES*8 | Per-lane decoded octet; lane n uses bits 8n+7:8n |
| lane_ilas | input | NUM_LANES | Per-lane flag, high during the alignment sequence |
| lane_mf | input | NUM_LANES*MF_W | Per-lane multiframe count within the sequence |
| sel_wr_en | input | 1 | Load the lane-select register |
| sel_lane | input | LANE_W | Lane-select value |
| rd_en | input | 1 | Read request |
| rd_word | input | WORD_W | Index of the word to read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data word |
| cap_done | output | NUM_LANES | Per-lane capture-complete status |
| cap_err | output | NUM_LANES | Per-lane capture-abort status |

## Verification
The bench builds the block with three lanes, fourteen octets and an 8-bit multiframe count. With three lanes the 2-bit select field can also hold the value 3, which names no lane, so the all-zero read for an unused select is reachable. The bench also checks that one lane's capture leaves the other two banks and their status bits untouched. Fourteen octets leave two unused bytes at the top of the last word, which exercises the zero padding.

// File: rtl/ilas_cap_pkg.sv
`timescale 1ns/1ps
package ilas_cap_pkg;
  // /Q/ control character code (K28.4)
  localparam logic [7:0] Q_CODE = 8'h9C;

  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_RUN  = 2'd1,
    CAP_HOLD = 2'd2
  } cap_state_e;
endpackage

// File: rtl/ilas_octet_bank.sv
`timescale 1ns/1ps
module ilas_octet_bank #(
  parameter int CFG_OCTETS = 14,
  localparam int IDX_W = (CFG_OCTETS > 1) ? $clog2(CFG_OCTETS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [7:0]              wr_data,
  output logic [CFG_OCTETS*8-1:0] bank_flat
);
  logic [7:0] mem [CFG_OCTETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CFG_OCTETS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  for (genvar g = 0; g < CFG_OCTETS; g++) begin : g_flat
    assign bank_flat[g*8 +: 8] = mem[g];
  end

  // the write index never leaves the window (R4)
  assert_idx_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_idx) < CFG_OCTETS));

  // a written octet is visible in the flat bank on the next cycle (R4)
  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (bank_flat[32'($past(wr_idx))*8 +: 8] == $past(wr_data)));
endmodule

// File: rtl/ilas_lane_capture.sv
`timescale 1ns/1ps
module ilas_lane_capture
  import ilas_cap_pkg::*;
#(
  parameter int CFG_OCTETS = 14,
  parameter int MF_W       = 8,
  parameter int CFG_MF     = 1,
  localparam int IDX_W = (CFG_OCTETS > 1) ? $clog2(CFG_OCTETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_ctrl,
  input  logic [7:0]       in_octet,
  input  logic             in_ilas,
  input  logic [MF_W-1:0]  in_mf,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             done,
  output logic             err
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CFG_OCTETS - 1);

  cap_state_e       state;
  logic [IDX_W-1:0] cnt;
  logic             q_hit;

  assign q_hit = in_valid && in_ctrl && (in_octet == Q_CODE) && in_ilas
                 && (in_mf == MF_W'(CFG_MF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CAP_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      unique case (state)
        CAP_IDLE: begin
          if (q_hit) begin
            state <= CAP_RUN;
            cnt   <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
          end
        end
        CAP_RUN: begin
          if (in_valid) begin
            if (in_ctrl) begin
              err   <= 1'b1;
              state <= CAP_HOLD;
            end else if (cnt == LAST_IDX) begin
              done  <= 1'b1;
              state <= CAP_HOLD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        CAP_HOLD: begin
          if (!in_ilas) state <= CAP_IDLE;
        end
        default: state <= CAP_IDLE;
      endcase
    end
  end

  assign wr_en   = (state == CAP_RUN) && in_valid && !in_ctrl;
  assign wr_idx  = cnt;
  assign wr_data = in_octet;

  assert_q_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CAP_IDLE && q_hit) |=> (state == CAP_RUN && !done && !err && cnt == '0));

  assert_idle_keeps_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CAP_IDLE && !q_hit) |=> ($stable(done) && $stable(err)));

  assert_done_on_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CAP_RUN && in_valid && !in_ctrl && cnt == LAST_IDX) |=> (done && state == CAP_HOLD));

  assert_no_early_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CAP_RUN && !(in_valid && cnt == LAST_IDX)) |=> !done);

  assert_ctrl_aborts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CAP_RUN && in_valid && in_ctrl) |=> (err && !done && state == CAP_HOLD));

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  assert_hold_is_deaf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CAP_HOLD && in_ilas) |=> (state == CAP_HOLD && $stable(done) && $stable(err)));
endmodule

// File: rtl/ilas_cfg_readout.sv
`timescale 1ns/1ps
module ilas_cfg_readout #(
  parameter int NUM_LANES  = 4,
  parameter int CFG_OCTETS = 14,
  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int WORDS  = (CFG_OCTETS + 3) / 4,
  localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int BANK_W = CFG_OCTETS * 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LANES*BANK_W-1:0] banks_flat,
  input  logic                        sel_wr_en,
  input  logic [LANE_W-1:0]           sel_lane,
  input  logic                        rd_en,
  input  logic [WORD_W-1:0]           rd_word,
  output logic                        rd_valid,
  output logic [31:0]                 rd_data
);
  localparam int PAD_W      = WORDS * 32;
  localparam int LAST_BYTES = CFG_OCTETS - 4 * (WORDS - 1);
  localparam logic [31:0] PAD_MASK = 32'hFFFF_FFFF << (8 * LAST_BYTES);

  logic [LANE_W-1:0] lane_sel;
  logic [BANK_W-1:0] sel_bytes;
  logic [PAD_W-1:0]  padded;
  logic [31:0]       word_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_sel <= '0;
    else if (sel_wr_en) lane_sel <= sel_lane;
  end

  always_comb begin
    sel_bytes = '0;
    for (int l = 0; l < NUM_LANES; l++) begin
      if (lane_sel == LANE_W'(l)) sel_bytes = banks_flat[l*BANK_W +: BANK_W];
    end
    padded   = PAD_W'(sel_bytes);
    word_mux = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (rd_word == WORD_W'(w)) word_mux = padded[w*32 +: 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= word_mux;
    end
  end

  assert_read_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  assert_no_stray_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  assert_pad_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_word) == WORD_W'(WORDS - 1)) |-> ((rd_data & PAD_MASK) == '0));

  assert_unsel_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && 32'($past(lane_sel)) >= NUM_LANES) |-> (rd_data == '0));
endmodule

// File: rtl/ilas_cfg_capture.sv
`timescale 1ns/1ps
module ilas_cfg_capture #(
  parameter int NUM_LANES  = 4,
  parameter int CFG_OCTETS = 14,
  parameter int MF_W       = 8,
  parameter int CFG_MF     = 1,
  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int WORDS  = (CFG_OCTETS + 3) / 4,
  localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_LANES-1:0]      lane_valid,
  input  logic [NUM_LANES-1:0]      lane_ctrl,
  input  logic [NUM_LANES*8-1:0]    lane_octet,
  input  logic [NUM_LANES-1:0]      lane_ilas,
  input  logic [NUM_LANES*MF_W-1:0] lane_mf,
  input  logic                      sel_wr_en,
  input  logic [LANE_W-1:0]         sel_lane,
  input  logic                      rd_en,
  input  logic [WORD_W-1:0]         rd_word,
  output logic                      rd_valid,
  output logic [31:0]               rd_data,
  output logic [NUM_LANES-1:0]      cap_done,
  output logic [NUM_LANES-1:0]      cap_err
);
  localparam int BANK_W = CFG_OCTETS * 8;
  localparam int IDX_W  = (CFG_OCTETS > 1) ? $clog2(CFG_OCTETS) : 1;

  logic [NUM_LANES*BANK_W-1:0] banks_flat;

  for (genvar n = 0; n < NUM_LANES; n++) begin : g_lane
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;

    ilas_lane_capture #(
      .CFG_OCTETS (CFG_OCTETS),
      .MF_W       (MF_W),
      .CFG_MF     (CFG_MF)
    ) cap_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (lane_valid[n]),
      .in_ctrl  (lane_ctrl[n]),
      .in_octet (lane_octet[n*8 +: 8]),
      .in_ilas  (lane_ilas[n]),
      .in_mf    (lane_mf[n*MF_W +: MF_W]),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .done     (cap_done[n]),
      .err      (cap_err[n])
    );

    ilas_octet_bank #(
      .CFG_OCTETS (CFG_OCTETS)
    ) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .bank_flat (banks_flat[n*BANK_W +: BANK_W])
    );
  end

  ilas_cfg_readout #(
    .NUM_LANES  (NUM_LANES),
    .CFG_OCTETS (CFG_OCTETS)
  ) rdo_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .banks_flat (banks_flat),
    .sel_wr_en  (sel_wr_en),
    .sel_lane   (sel_lane),
    .rd_en      (rd_en),
    .rd_word    (rd_word),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );
endmodule

// File: tb/ilas_cfg_capture_tb_top.sv
`timescale 1ns/1ps
module ilas_cfg_capture_tb_top;
  localparam int NL   = 3;
  localparam int NOCT = 14;
  localparam int MFW  = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NL-1:0]   lane_valid = '0;
  logic [NL-1:0]   lane_ctrl = '0;
  logic [NL*8-1:0] lane_octet = '0;
  logic [NL-1:0]   lane_ilas = '0;
  logic [NL*MFW-1:0] lane_mf = '0;
  logic            sel_wr_en = 1'b0;
  logic [1:0]      sel_lane = '0;
  logic            rd_en = 1'b0;
  logic [1:0]      rd_word = '0;
  logic            rd_valid;
  logic [31:0]     rd_data;
  logic [NL-1:0]   cap_done;
  logic [NL-1:0]   cap_err;

  int checks = 0;
  int errors = 0;
  logic [7:0]  exp_mem [NL][NOCT];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  ilas_cfg_capture #(.NUM_LANES(NL), .CFG_OCTETS(NOCT), .MF_W(MFW), .CFG_MF(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .lane_valid(lane_valid), .lane_ctrl(lane_ctrl),
    .lane_octet(lane_octet), .lane_ilas(lane_ilas), .lane_mf(lane_mf),
    .sel_wr_en(sel_wr_en), .sel_lane(sel_lane), .rd_en(rd_en), .rd_word(rd_word),
    .rd_valid(rd_valid), .rd_data(rd_data), .cap_done(cap_done), .cap_err(cap_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a read response appears (R8, R11)
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R11 actual=unexpected rd_valid expected=no response");
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic set_phase(input int ln, input bit ilas, input int mf);
    lane_ilas[ln] = ilas;
    lane_mf[ln*MFW +: MFW] = MFW'(mf);
  endtask

  task automatic beat(input int ln, input bit c, input logic [7:0] o);
    lane_valid = '0;
    lane_valid[ln] = 1'b1;
    lane_ctrl[ln] = c;
    lane_octet[ln*8 +: 8] = o;
    @(negedge clk);
    lane_valid = '0;
    lane_ctrl = '0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  // driver: stores expected word, then performs select write and read
  task automatic read_chk(input int ln, input int w, input string tag);
    logic [31:0] e;
    e = '0;
    for (int b = 0; b < 4; b++) begin
      if (ln < NL && (4*w + b) < NOCT) e[8*b +: 8] = exp_mem[ln][4*w + b];
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    sel_wr_en = 1'b1;
    sel_lane = 2'(ln);
    @(negedge clk);
    sel_wr_en = 1'b0;
    rd_en = 1'b1;
    rd_word = 2'(w);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic capture14(input int ln, input logic [7:0] base, input bit gaps);
    beat(ln, 1'b1, 8'h9C);
    for (int i = 0; i < NOCT; i++) begin
      if (i == NOCT - 1) check("R4", 32'(cap_done[ln]), 32'd0);
      exp_mem[ln][i] = base + 8'(i);
      beat(ln, 1'b0, base + 8'(i));
      if (gaps && (i % 2 == 1)) idle();
    end
  endtask

  initial begin
    for (int l = 0; l < NL; l++)
      for (int i = 0; i < NOCT; i++) exp_mem[l][i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1", 32'(cap_done), 32'd0);
    check("R1", 32'(cap_err), 32'd0);
    check("R1", 32'(rd_valid), 32'd0);
    read_chk(0, 0, "R1");
    read_chk(2, 3, "R1");

    // R3: wrong multiframe, missing control flag, alignment flag low
    set_phase(0, 1'b1, 0);
    beat(0, 1'b1, 8'h9C);
    set_phase(0, 1'b1, 1);
    beat(0, 1'b0, 8'h9C);
    set_phase(0, 1'b0, 1);
    beat(0, 1'b1, 8'h9C);
    set_phase(0, 1'b1, 2);
    beat(0, 1'b1, 8'h9C);
    set_phase(0, 1'b1, 1);
    beat(0, 1'b0, 8'hAA);
    beat(0, 1'b0, 8'hAB);
    check("R3", 32'(cap_done[0]), 32'd0);
    read_chk(0, 0, "R3");

    // R2, R4: capture on lane 0 with gaps
    capture14(0, 8'h20, 1'b1);
    check("R4", 32'(cap_done[0]), 32'd1);
    check("R2", 32'(cap_err[0]), 32'd0);

    // R6: held after done, extra octets and /Q/ ignored
    beat(0, 1'b0, 8'h77);
    beat(0, 1'b1, 8'h9C);
    beat(0, 1'b0, 8'h66);
    check("R6", 32'(cap_done[0]), 32'd1);
    read_chk(0, 0, "R8");
    read_chk(0, 1, "R8");
    read_chk(0, 2, "R8");
    read_chk(0, 3, "R9");

    // R5: abort on lane 1
    set_phase(1, 1'b1, 1);
    beat(1, 1'b1, 8'h9C);
    for (int i = 0; i < 5; i++) begin
      exp_mem[1][i] = 8'h50 + 8'(i);
      beat(1, 1'b0, 8'h50 + 8'(i));
    end
    beat(1, 1'b1, 8'hBC);
    check("R5", 32'(cap_err[1]), 32'd1);
    check("R5", 32'(cap_done[1]), 32'd0);
    beat(1, 1'b0, 8'h99);
    beat(1, 1'b0, 8'h98);
    read_chk(1, 0, "R5");
    read_chk(1, 1, "R5");

    // R7: lane 2 capture leaves lanes 0 and 1 intact
    set_phase(2, 1'b1, 1);
    capture14(2, 8'hC0, 1'b0);
    check("R7", 32'(cap_done), 32'b101);
    check("R7", 32'(cap_err), 32'b010);
    read_chk(0, 1, "R7");
    read_chk(1, 1, "R7");
    read_chk(2, 2, "R7");

    // R6: new alignment sequence re-arms lane 0 and overwrites
    set_phase(0, 1'b0, 0);
    idle();
    set_phase(0, 1'b1, 1);
    beat(0, 1'b1, 8'h9C);
    check("R2", 32'(cap_done[0]), 32'd0);
    for (int i = 0; i < NOCT; i++) begin
      exp_mem[0][i] = 8'h80 + 8'(i);
      beat(0, 1'b0, 8'h80 + 8'(i));
    end
    check("R6", 32'(cap_done[0]), 32'd1);
    for (int w = 0; w < 4; w++) read_chk(0, w, "R6");

    // R2: new /Q/ on lane 1 clears its error bit
    set_phase(1, 1'b0, 0);
    idle();
    set_phase(1, 1'b1, 1);
    beat(1, 1'b1, 8'h9C);
    check("R2", 32'(cap_err[1]), 32'd0);

    // R10: select beyond the lane count
    read_chk(3, 0, "R10");
    read_chk(3, 2, "R10");

    // R11: no response without a request
    idle();
    idle();
    check("R11", 32'(rd_valid), 32'd0);
    check("R11", 32'(exp_q.size()), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule